// File: doc/BRIEF.md
# Memory-to-Memory Move Processor with Interrupt Exchange

This block is a processor with a single operation: copy one memory word to another. Each instruction occupies two consecutive words. The first word is the address of the source and the second is the address of the destination. The sequencer makes four single-cycle accesses per instruction. It reads the source address at the program counter, then the destination address at the next word, then the operand at the source, and it writes that operand to the destination. The PC advances after each of the two fetches.

The program counter, an interrupt-return register and the interrupt enable sit at the top three addresses of the address space. They are decoded inside the block and never reach the external memory bus. A program jumps by moving a word into the PC address. It returns from an interrupt by moving the return register into the PC. After each move the block checks whether any device is requesting service. If one is and a one-move-delayed shadow of the enable is set, the PC and the return register trade contents and both enable flags drop. Because of the shadow, a handler can re-enable interrupts and then make its return jump before the next interrupt can enter.

Top module: `xfer_core`

## Requirements
- R1: An asynchronous active-low reset clears the PC, the return register, the enable and its shadow. The first bus access after reset is a read at address 0, and `irq_taken` is low.
- R2: An instruction takes exactly four cycles. The accesses are, in order: read at PC, read at PC+1, read at the source address, then write at the destination address (`mem_we` high only in that cycle). The write data is the word read in the previous access.
- R3: Address 0xFFFF is the PC. Reading it during a move returns the address of the next instruction. Writing it makes the next fetch start at the written address.
- R4: Address 0xFFFD is the enable. A write sets the enable from data bit 0 and ignores the other bits. A read returns the enable in bit 0 and zero in all other bits.
- R5: Accesses to 0xFFFD, 0xFFFE and 0xFFFF keep `mem_en` low. All other accesses assert `mem_en`. External read data is taken one cycle after the address.
- R6: At the end of a move, if a request is present and the shadow enable is 1, the PC and the return register exchange contents and the enable and shadow become 0. If either condition is absent, no exchange occurs.
- R7: At the end of a move without an exchange, the shadow takes the enable value as left by that move. As a result, the move that sets the enable is never followed by an exchange, but the next move can be.
- R8: A request is present when any bit of `irq_req` is 1.
- R9: When the write of a move targets the PC or the return register in the same cycle as an exchange, the exchange uses the newly written value.
- R10: `irq_taken` is high for exactly the one cycle after each exchange.
- R11: Address 0xFFFE is the return register. It can be read and written by moves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_req | input | N_DEV | Device request levels |
| mem_en | output | 1 | External memory access strobe |
| mem_we | output | 1 | External write strobe |
| mem_addr | output | DW | Access address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid one cycle after the address |
| irq_taken | output | 1 | One-cycle pulse after an interrupt exchange |

## Verification
The final cycle of a move can both commit the move's write and perform the interrupt exchange. When the write targets the return register or the PC, the two updates collide. The bench provokes this by enabling interrupts with a request held, so that the next move, which writes the return register, ends with an exchange. It then judges the outcome from the next fetch address, which must be the value just written. It also reads the return register back inside the handler, where it must hold the address that followed the colliding move.

// File: rtl/xfer_pkg.sv
package xfer_pkg;

   // Sequencer phases, one memory access each
   typedef enum logic [1:0] {
      ST_FSRC = 2'd0,
      ST_FDST = 2'd1,
      ST_RDOP = 2'd2,
      ST_WROP = 2'd3
   } xfer_state_e;

   // Which control register an address selects
   typedef enum logic [1:0] {
      MAP_NONE = 2'd0,
      MAP_IEN  = 2'd1,
      MAP_RET  = 2'd2,
      MAP_PC   = 2'd3
   } map_sel_e;

endpackage

// File: rtl/xfer_irq_or.sv
module xfer_irq_or #(
   parameter int N_REQ = 4
) (
   input  logic [N_REQ-1:0] req,
   output logic             any_o
);

   if (N_REQ < 1) begin : g_bad_nreq
      $error("xfer_irq_or: N_REQ must be at least 1");
   end

   logic [N_REQ:0] chain;
   assign chain[0] = 1'b0;

   for (genvar i = 0; i < N_REQ; i++) begin : g_or
      assign chain[i+1] = chain[i] | req[i];
   end

   assign any_o = chain[N_REQ];

endmodule

// File: rtl/xfer_ctlregs.sv
module xfer_ctlregs
   import xfer_pkg::*;
#(
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          pc_inc,
   input  logic [DW-1:0] rd_addr,
   output logic          rd_hit,
   output logic [DW-1:0] rd_val,
   input  logic          move_end,
   input  logic [DW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   output logic          wr_hit,
   input  logic          irq_any,
   output logic          take,
   output logic [DW-1:0] pc,
   output logic          ien,
   output logic          shd
);

   localparam logic [DW-1:0] A_PC  = {DW{1'b1}};
   localparam logic [DW-1:0] A_RET = {{(DW-1){1'b1}}, 1'b0};
   localparam logic [DW-1:0] A_IEN = {{(DW-2){1'b1}}, 2'b01};
   localparam logic [DW-1:0] ONE   = {{(DW-1){1'b0}}, 1'b1};

   function automatic map_sel_e sel_of(input logic [DW-1:0] a);
      if (a == A_PC)       return MAP_PC;
      else if (a == A_RET) return MAP_RET;
      else if (a == A_IEN) return MAP_IEN;
      else                 return MAP_NONE;
   endfunction

   logic [DW-1:0] pc_q, ret_q;
   logic          ie_q, sh_q;
   map_sel_e      rsel, wsel;
   logic [DW-1:0] pc_n, ret_n;
   logic          ie_n;

   assign rsel   = sel_of(rd_addr);
   assign wsel   = sel_of(wr_addr);
   assign rd_hit = (rsel != MAP_NONE);
   assign wr_hit = (wsel != MAP_NONE);

   always_comb begin
      unique case (rsel)
         MAP_PC:  rd_val = pc_q;
         MAP_RET: rd_val = ret_q;
         MAP_IEN: rd_val = {{(DW-1){1'b0}}, ie_q};
         default: rd_val = '0;
      endcase
   end

   // Register values as the move's write leaves them
   always_comb begin
      pc_n  = (wsel == MAP_PC)  ? wr_data    : pc_q;
      ret_n = (wsel == MAP_RET) ? wr_data    : ret_q;
      ie_n  = (wsel == MAP_IEN) ? wr_data[0] : ie_q;
   end

   assign take = move_end & irq_any & sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q  <= '0;
         ret_q <= '0;
         ie_q  <= 1'b0;
         sh_q  <= 1'b0;
      end else if (pc_inc) begin
         pc_q <= pc_q + ONE;
      end else if (move_end) begin
         if (take) begin
            pc_q  <= ret_n;
            ret_q <= pc_n;
            ie_q  <= 1'b0;
            sh_q  <= 1'b0;
         end else begin
            pc_q  <= pc_n;
            ret_q <= ret_n;
            ie_q  <= ie_n;
            sh_q  <= ie_n;
         end
      end
   end

   assign pc  = pc_q;
   assign ien = ie_q;
   assign shd = sh_q;

endmodule

// File: rtl/xfer_seq.sv
module xfer_seq
   import xfer_pkg::*;
#(
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [DW-1:0] pc,
   input  logic [DW-1:0] rd_word,
   output xfer_state_e   st,
   output logic [DW-1:0] acc_addr,
   output logic          acc_we,
   output logic [DW-1:0] acc_wdata,
   output logic          pc_inc,
   output logic          move_end
);

   xfer_state_e   st_q, st_n;
   logic [DW-1:0] src_q, dst_q;

   always_comb begin
      st_n      = st_q;
      acc_addr  = pc;
      acc_we    = 1'b0;
      acc_wdata = rd_word;
      pc_inc    = 1'b0;
      move_end  = 1'b0;
      unique case (st_q)
         ST_FSRC: begin
            pc_inc = 1'b1;
            st_n   = ST_FDST;
         end
         ST_FDST: begin
            pc_inc = 1'b1;
            st_n   = ST_RDOP;
         end
         ST_RDOP: begin
            acc_addr = src_q;
            st_n     = ST_WROP;
         end
         default: begin
            acc_addr = dst_q;
            acc_we   = 1'b1;
            move_end = 1'b1;
            st_n     = ST_FSRC;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_FSRC;
         src_q <= '0;
         dst_q <= '0;
      end else begin
         st_q <= st_n;
         if (st_q == ST_FDST) src_q <= rd_word;
         if (st_q == ST_RDOP) dst_q <= rd_word;
      end
   end

   assign st = st_q;

endmodule

// File: rtl/xfer_core.sv
module xfer_core
   import xfer_pkg::*;
#(
   parameter int DW    = 16,
   parameter int N_DEV = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_DEV-1:0] irq_req,
   output logic             mem_en,
   output logic             mem_we,
   output logic [DW-1:0]    mem_addr,
   output logic [DW-1:0]    mem_wdata,
   input  logic [DW-1:0]    mem_rdata,
   output logic             irq_taken
);

   if (DW < 4) begin : g_bad_dw
      $error("xfer_core: DW must be at least 4");
   end

   xfer_state_e   st;
   logic [DW-1:0] acc_addr, acc_wdata, pc, rd_val, rd_word, map_q;
   logic          acc_we, pc_inc, move_end, rd_hit, wr_hit;
   logic          irq_any, take, ien, shd, map_use_q, taken_q;

   xfer_irq_or #(.N_REQ(N_DEV)) u_irq_or (
      .req   (irq_req),
      .any_o (irq_any)
   );

   xfer_seq #(.DW(DW)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .pc        (pc),
      .rd_word   (rd_word),
      .st        (st),
      .acc_addr  (acc_addr),
      .acc_we    (acc_we),
      .acc_wdata (acc_wdata),
      .pc_inc    (pc_inc),
      .move_end  (move_end)
   );

   xfer_ctlregs #(.DW(DW)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .pc_inc   (pc_inc),
      .rd_addr  (acc_addr),
      .rd_hit   (rd_hit),
      .rd_val   (rd_val),
      .move_end (move_end),
      .wr_addr  (acc_addr),
      .wr_data  (acc_wdata),
      .wr_hit   (wr_hit),
      .irq_any  (irq_any),
      .take     (take),
      .pc       (pc),
      .ien      (ien),
      .shd      (shd)
   );

   // Mapped reads return with the same one-cycle latency as the bus
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         map_q     <= '0;
         map_use_q <= 1'b0;
         taken_q   <= 1'b0;
      end else begin
         map_q     <= rd_val;
         map_use_q <= rd_hit & ~acc_we;
         taken_q   <= take;
      end
   end

   assign rd_word   = map_use_q ? map_q : mem_rdata;
   assign mem_en    = ~(acc_we ? wr_hit : rd_hit);
   assign mem_we    = acc_we & ~wr_hit;
   assign mem_addr  = acc_addr;
   assign mem_wdata = acc_wdata;
   assign irq_taken = taken_q;

endmodule

// File: rtl/xfer_core_chk.sv
module xfer_core_chk
   import xfer_pkg::*;
#(
   parameter int DW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input xfer_state_e   st,
   input logic          mem_en,
   input logic          mem_we,
   input logic [DW-1:0] mem_addr,
   input logic          irq_taken,
   input logic          ien,
   input logic          shd
);

   localparam logic [DW-1:0] A_IEN = {{(DW-2){1'b1}}, 2'b01};

   // R5
   bus_unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_en |-> (mem_addr < A_IEN));

   // R2
   phase_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_WROP) |=> (st == ST_FSRC));

   // R2
   write_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> !mem_we);

   // R10
   taken_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_taken |=> !irq_taken);

   // R6
   taken_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_taken |-> (!ien && !shd));

   // R7
   shadow_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(shd) |-> ien);

endmodule

bind xfer_core xfer_core_chk #(.DW(DW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .st        (st),
   .mem_en    (mem_en),
   .mem_we    (mem_we),
   .mem_addr  (mem_addr),
   .irq_taken (irq_taken),
   .ien       (ien),
   .shd       (shd)
);

// File: tb/xfer_core_bench.sv
`timescale 1ns/1ps
module xfer_core_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  irq_req = '0;
   logic        mem_en, mem_we, irq_taken;
   logic [15:0] mem_addr, mem_wdata, mem_rdata;

   logic [15:0] ram [256];
   logic [15:0] rd_q;
   logic        ld_en = 1'b0, ld_clr = 1'b0;
   logic [7:0]  ld_a = '0;
   logic [15:0] ld_d = '0;

   int nchk = 0, nerr = 0, npulse = 0;

   always #4 clk = ~clk;

   xfer_core u_xfer_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .irq_req   (irq_req),
      .mem_en    (mem_en),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .mem_rdata (mem_rdata),
      .irq_taken (irq_taken)
   );

   always @(posedge clk) begin
      if (ld_clr) begin
         for (int i = 0; i < 256; i++) ram[i] <= '0;
      end else if (ld_en) begin
         ram[ld_a] <= ld_d;
      end else if (mem_en) begin
         if (mem_we) ram[mem_addr[7:0]] <= mem_wdata;
         rd_q <= ram[mem_addr[7:0]];
      end
   end
   assign mem_rdata = rd_q;

   always @(negedge clk) if (rst_n && irq_taken) npulse++;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic poke(input logic [7:0] a, input logic [15:0] d);
      ld_en = 1'b1; ld_a = a; ld_d = d;
      @(negedge clk);
      ld_en = 1'b0;
   endtask

   task automatic mv(input logic [7:0] a, input logic [15:0] s, input logic [15:0] d);
      poke(a, s);
      poke(a + 8'd1, d);
   endtask

   task automatic hold_and_clear();
      rst_n = 1'b0;
      ld_clr = 1'b1;
      @(negedge clk);
      ld_clr = 1'b0;
   endtask

   task automatic t_sequence();
      hold_and_clear();
      mv(8'h00, 16'h0040, 16'h0041);
      mv(8'h02, 16'hFFFF, 16'h0042);
      poke(8'h40, 16'h1234);
      rst_n = 1'b1;
      check("R1 first fetch addr", mem_addr, 16'h0000);
      check("R2 first fetch is read", {mem_en, mem_we}, 2'b10);
      cyc(1); check("R2 dest fetch addr", mem_addr, 16'h0001);
      cyc(1); check("R2 operand read addr", {mem_we, mem_addr}, {1'b0, 16'h0040});
      cyc(1); check("R2 operand write", {mem_we, mem_addr, mem_wdata}, {1'b1, 16'h0041, 16'h1234});
      cyc(1); check("R2 moved word", ram[8'h41], 16'h1234);
      check("R2 next fetch addr", mem_addr, 16'h0002);
      cyc(2); check("R5 mapped read off bus", mem_en, 1'b0);
      cyc(2); check("R3 PC read value", ram[8'h42], 16'h0004);
   endtask

   task automatic t_jump();
      hold_and_clear();
      mv(8'h00, 16'h0030, 16'hFFFF);
      poke(8'h30, 16'h0020);
      mv(8'h20, 16'hFFFF, 16'h0050);
      rst_n = 1'b1;
      cyc(4); check("R3 jump target fetch", mem_addr, 16'h0020);
      cyc(4); check("R3 PC after jump", ram[8'h50], 16'h0022);
   endtask

   task automatic t_enable_ret();
      hold_and_clear();
      mv(8'h00, 16'h0030, 16'hFFFD);
      mv(8'h02, 16'hFFFD, 16'h0050);
      mv(8'h04, 16'h0031, 16'hFFFD);
      mv(8'h06, 16'hFFFD, 16'h0051);
      mv(8'h08, 16'h0032, 16'hFFFE);
      mv(8'h0A, 16'hFFFE, 16'h0053);
      poke(8'h30, 16'h0002);
      poke(8'h31, 16'h0003);
      poke(8'h32, 16'hBEEF);
      poke(8'h50, 16'h5555);
      rst_n = 1'b1;
      cyc(24);
      check("R4 enable ignores upper bits", ram[8'h50], 16'h0000);
      check("R4 enable reads bit0 only", ram[8'h51], 16'h0001);
      check("R11 return reg read back", ram[8'h53], 16'hBEEF);
   endtask

   task automatic t_irq_basic();
      int base;
      hold_and_clear();
      mv(8'h00, 16'h0030, 16'hFFFE);
      mv(8'h02, 16'h0031, 16'hFFFD);
      mv(8'h04, 16'h0032, 16'h0050);
      mv(8'h80, 16'hFFFE, 16'h0051);
      mv(8'h82, 16'hFFFD, 16'h0052);
      poke(8'h30, 16'h0080);
      poke(8'h31, 16'h0001);
      poke(8'h32, 16'hAAAA);
      poke(8'h52, 16'h7777);
      irq_req = 4'b0100;
      base = npulse;
      rst_n = 1'b1;
      cyc(11); check("R7 no exchange after enabling move", npulse - base, 0);
      cyc(1);  check("R10 taken pulse high", irq_taken, 1'b1);
      check("R6 R8 fetch at handler", mem_addr, 16'h0080);
      check("R6 move completed before exchange", ram[8'h50], 16'hAAAA);
      cyc(1);  check("R10 taken pulse one cycle", irq_taken, 1'b0);
      cyc(3);  check("R6 return reg holds resume addr", ram[8'h51], 16'h0006);
      cyc(4);  check("R6 enable cleared", ram[8'h52], 16'h0000);
      check("R6 single exchange", npulse - base, 1);
      irq_req = '0;
   endtask

   task automatic t_no_enable();
      int base;
      hold_and_clear();
      mv(8'h00, 16'h0030, 16'h0050);
      mv(8'h02, 16'h0031, 16'h0051);
      mv(8'h04, 16'h0032, 16'h0052);
      irq_req = 4'b1111;
      base = npulse;
      rst_n = 1'b1;
      cyc(12);
      check("R6 no exchange while disabled", npulse - base, 0);
      check("R6 linear flow while disabled", mem_addr, 16'h0006);
      irq_req = '0;
   endtask

   task automatic t_collision();
      hold_and_clear();
      mv(8'h00, 16'h0030, 16'hFFFD);
      mv(8'h02, 16'h0031, 16'hFFFE);
      mv(8'h90, 16'hFFFE, 16'h0052);
      mv(8'h92, 16'hFFFD, 16'h0053);
      poke(8'h30, 16'h0001);
      poke(8'h31, 16'h0090);
      poke(8'h53, 16'h7777);
      irq_req = 4'b0001;
      rst_n = 1'b1;
      cyc(7); check("R5 mapped write off bus", {mem_en, mem_we}, 2'b00);
      cyc(1); check("R9 exchange uses written return", mem_addr, 16'h0090);
      check("R8 R10 taken on bit0 request", irq_taken, 1'b1);
      cyc(4); check("R9 return reg after collision", ram[8'h52], 16'h0004);
      cyc(4); check("R9 enable cleared on collision", ram[8'h53], 16'h0000);
      irq_req = '0;
   endtask

   task automatic t_reset();
      hold_and_clear();
      mv(8'h00, 16'hFFFE, 16'h0050);
      mv(8'h02, 16'hFFFD, 16'h0051);
      mv(8'h04, 16'hFFFF, 16'h0052);
      poke(8'h50, 16'h1111);
      poke(8'h51, 16'h1111);
      rst_n = 1'b1;
      check("R1 fetch at zero after reset", mem_addr, 16'h0000);
      check("R1 taken low after reset", irq_taken, 1'b0);
      cyc(12);
      check("R1 return reg cleared", ram[8'h50], 16'h0000);
      check("R1 enable cleared", ram[8'h51], 16'h0000);
      check("R1 PC count from zero", ram[8'h52], 16'h0006);
   endtask

   initial begin
      #(8 * 150000);
      nerr++;
      $display("FAIL R2 watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

   initial begin
      @(negedge clk);
      t_sequence();
      t_jump();
      t_enable_ret();
      t_irq_basic();
      t_no_enable();
      t_collision();
      t_reset();
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

endmodule